// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit resolves one jump-class instruction of a 64-bit register machine per accepted request. It takes the 4-bit jump operation, a width bit that selects either a full 64-bit compare or a compare on the low 32 bits, and a bit that picks the second operand. That operand is either the source register or the sign-extended 32-bit immediate. From these it decides whether control flow is redirected, and it computes the next program counter in instruction slots. It also flags program-local calls, helper calls, program exit and encodings that are not allowed.

A request is accepted on any rising edge where `in_valid` is high. The result registers load on that edge. The output state machine has two states. It moves from `OS_IDLE` to `OS_RESULT` on the transition *accept*, stays in `OS_RESULT` while requests keep arriving (*accept again*), and returns to `OS_IDLE` on the transition *drain* when a cycle passes with no request. `out_valid` is high exactly in `OS_RESULT`. The result outputs keep their last values while no request is accepted. Helper dispatch, return-address tracking and pipeline flushing are left to the surrounding core.

Top module: `bcu_branch_unit`

## Requirements
- R1: After reset, and until the first request is accepted, `out_valid`, `taken`, `call_local`, `call_helper`, `exit_req` and `illegal` are 0 and `next_pc` is 0.
- R2: `out_valid` is 1 in the cycle after an edge with `in_valid` high and 0 in the cycle after an edge with `in_valid` low. Across a cycle with no request, `taken` and `next_pc` do not change.
- R3: Code 0x1 is taken when the operands are equal. Code 0x5 is taken when they differ. Code 0x4 is taken when their bitwise AND is nonzero.
- R4: Unsigned compares are taken when destination > operand (0x2), >= (0x3), < (0xA) and <= (0xB).
- R5: Signed two's-complement compares are taken when destination > operand (0x6), >= (0x7), < (0xC) and <= (0xD).
- R6: With `wide_cmp`=0, only bits 31:0 of each operand take part in a compare, and bit 31 is the sign for the signed codes. With `wide_cmp`=1, all 64 bits take part.
- R7: With `src_is_reg`=0, the second operand is `imm_val` sign-extended to 64 bits and `src_val` is ignored. With `src_is_reg`=1, it is `src_val`.
- R8: A result that is not taken gives `next_pc` = `pc_in`+1. A taken result gives `next_pc` = `pc_in`+1+sign-extended displacement. Both wrap modulo 2^64.
- R9: Code 0x0 is always taken. Its displacement is `off_val` when `wide_cmp`=1 and `imm_val` when `wide_cmp`=0.
- R10: Code 0x8 with `call_kind`=1 is taken with displacement `off_val` and sets `call_local`. With `call_kind` 0 or 2 it sets `call_helper` and is not taken. With `call_kind`=3 it sets `illegal`.
- R11: Code 0x9 with `wide_cmp`=1 sets `exit_req` and is not taken. With `wide_cmp`=0 it sets `illegal` instead.
- R12: Codes 0xE and 0xF set `illegal` and are not taken. At most one of `call_local`, `call_helper`, `exit_req` and `illegal` is ever set, and `illegal` never comes with `taken`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| jcode | input | 4 | Jump operation code |
| wide_cmp | input | 1 | 1 = 64-bit class, 0 = 32-bit class |
| src_is_reg | input | 1 | 1 = second operand is the register, 0 = immediate |
| call_kind | input | 2 | Call target kind for code 0x8 |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| imm_val | input | 32 | Immediate field |
| off_val | input | 16 | Signed offset field |
| pc_in | input | 64 | Current program counter, in slots |
| out_valid | output | 1 | Result valid |
| taken | output | 1 | Control flow is redirected |
| next_pc | output | 64 | Next program counter |
| call_local | output | 1 | Program-local call |
| call_helper | output | 1 | Helper call |
| exit_req | output | 1 | Program exit |
| illegal | output | 1 | Encoding not allowed |

## Verification
A program-local call raises the call indication and the branch redirect in the same cycle. The bench provokes this by sweeping code 0x8 across every `call_kind` value and every operand and PC pattern. In each such cycle it checks that `call_local` and `taken` are both set and that `next_pc` carries the offset-based target. For the helper kinds it checks that only `call_helper` is set and that the PC advances by one. The same sweep runs every compare code at both widths and with both operand sources. Operand patterns sit on the 32-bit and 64-bit sign boundaries, and PC values sit next to the wrap point.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

    typedef enum logic [3:0] {
        JOP_ALWAYS = 4'h0,
        JOP_EQ     = 4'h1,
        JOP_UGT    = 4'h2,
        JOP_UGE    = 4'h3,
        JOP_ANDNZ  = 4'h4,
        JOP_NE     = 4'h5,
        JOP_SGT    = 4'h6,
        JOP_SGE    = 4'h7,
        JOP_CALL   = 4'h8,
        JOP_EXIT   = 4'h9,
        JOP_ULT    = 4'hA,
        JOP_ULE    = 4'hB,
        JOP_SLT    = 4'hC,
        JOP_SLE    = 4'hD,
        JOP_RSV_E  = 4'hE,
        JOP_RSV_F  = 4'hF
    } jop_e;

    typedef enum logic [1:0] {
        DSP_NONE   = 2'd0,
        DSP_OFFSET = 2'd1,
        DSP_IMM    = 2'd2
    } disp_sel_e;

    typedef enum logic [1:0] {
        CK_HELPER_ADDR = 2'd0,
        CK_LOCAL       = 2'd1,
        CK_HELPER_ID   = 2'd2,
        CK_RESERVED    = 2'd3
    } call_kind_e;

    typedef enum logic {
        OS_IDLE   = 1'b0,
        OS_RESULT = 1'b1
    } out_state_e;

    typedef struct packed {
        logic      use_cond;
        logic      force_taken;
        disp_sel_e disp;
        logic      call_local;
        logic      call_helper;
        logic      exit_req;
        logic      illegal;
    } jdec_t;

endpackage

// File: rtl/bcu_decode.sv
module bcu_decode
    import bcu_pkg::*;
(
    input  logic [3:0] jcode,
    input  logic       wide_cmp,
    input  logic [1:0] call_kind,
    output jdec_t      dec
);

    always_comb begin
        dec = '0;
        dec.disp = DSP_OFFSET;
        unique case (jop_e'(jcode))
            JOP_ALWAYS: begin
                dec.force_taken = 1'b1;
                dec.disp        = wide_cmp ? DSP_OFFSET : DSP_IMM;
            end
            JOP_EQ, JOP_UGT, JOP_UGE, JOP_ANDNZ, JOP_NE, JOP_SGT, JOP_SGE,
            JOP_ULT, JOP_ULE, JOP_SLT, JOP_SLE: begin
                dec.use_cond = 1'b1;
            end
            JOP_CALL: begin
                unique case (call_kind_e'(call_kind))
                    CK_LOCAL: begin
                        dec.force_taken = 1'b1;
                        dec.call_local  = 1'b1;
                    end
                    CK_HELPER_ADDR, CK_HELPER_ID: begin
                        dec.call_helper = 1'b1;
                        dec.disp        = DSP_NONE;
                    end
                    CK_RESERVED: begin
                        dec.illegal = 1'b1;
                        dec.disp    = DSP_NONE;
                    end
                endcase
            end
            JOP_EXIT: begin
                dec.disp = DSP_NONE;
                if (wide_cmp) dec.exit_req = 1'b1;
                else          dec.illegal  = 1'b1;
            end
            JOP_RSV_E, JOP_RSV_F: begin
                dec.illegal = 1'b1;
                dec.disp    = DSP_NONE;
            end
        endcase
    end

endmodule

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval
    import bcu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [3:0]      jcode,
    input  logic            wide_cmp,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic            cond_true
);

    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] ua, ub;
    logic [XLEN-1:0] sa, sb;
    logic            is_eq, is_ult, is_slt, any_and;

    always_comb begin
        if (wide_cmp) begin
            ua = opa;
            ub = opb;
            sa = opa;
            sb = opb;
        end else begin
            ua = {{(XLEN-HALF){1'b0}}, opa[HALF-1:0]};
            ub = {{(XLEN-HALF){1'b0}}, opb[HALF-1:0]};
            sa = {{(XLEN-HALF){opa[HALF-1]}}, opa[HALF-1:0]};
            sb = {{(XLEN-HALF){opb[HALF-1]}}, opb[HALF-1:0]};
        end
    end

    assign is_eq   = (ua == ub);
    assign is_ult  = (ua < ub);
    assign is_slt  = ($signed(sa) < $signed(sb));
    assign any_and = |(ua & ub);

    always_comb begin
        cond_true = 1'b0;
        unique case (jop_e'(jcode))
            JOP_EQ:    cond_true = is_eq;
            JOP_NE:    cond_true = !is_eq;
            JOP_ANDNZ: cond_true = any_and;
            JOP_UGT:   cond_true = !is_ult && !is_eq;
            JOP_UGE:   cond_true = !is_ult;
            JOP_ULT:   cond_true = is_ult;
            JOP_ULE:   cond_true = is_ult || is_eq;
            JOP_SGT:   cond_true = !is_slt && !is_eq;
            JOP_SGE:   cond_true = !is_slt;
            JOP_SLT:   cond_true = is_slt;
            JOP_SLE:   cond_true = is_slt || is_eq;
            JOP_ALWAYS, JOP_CALL, JOP_EXIT, JOP_RSV_E, JOP_RSV_F:
                       cond_true = 1'b0;
        endcase
    end

endmodule

// File: rtl/bcu_target_gen.sv
module bcu_target_gen
    import bcu_pkg::*;
#(
    parameter int PC_W  = 64,
    parameter int IMM_W = 32,
    parameter int OFF_W = 16
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [IMM_W-1:0] imm,
    input  logic [OFF_W-1:0] off,
    input  disp_sel_e        disp,
    input  logic             taken,
    output logic [PC_W-1:0]  target
);

    logic [PC_W-1:0] off_ext, imm_ext, disp_v;

    generate
        if (PC_W > OFF_W) begin : g_off_sx
            assign off_ext = {{(PC_W-OFF_W){off[OFF_W-1]}}, off};
        end else begin : g_off_tr
            assign off_ext = off[PC_W-1:0];
        end
        if (PC_W > IMM_W) begin : g_imm_sx
            assign imm_ext = {{(PC_W-IMM_W){imm[IMM_W-1]}}, imm};
        end else begin : g_imm_tr
            assign imm_ext = imm[PC_W-1:0];
        end
    endgenerate

    always_comb begin
        disp_v = '0;
        if (taken) begin
            unique case (disp)
                DSP_OFFSET: disp_v = off_ext;
                DSP_IMM:    disp_v = imm_ext;
                default:    disp_v = '0;
            endcase
        end
    end

    assign target = pc + PC_W'(1) + disp_v;

endmodule

// File: rtl/bcu_branch_unit.sv
module bcu_branch_unit
    import bcu_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int PC_W  = 64,
    parameter int IMM_W = 32,
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       jcode,
    input  logic             wide_cmp,
    input  logic             src_is_reg,
    input  logic [1:0]       call_kind,
    input  logic [XLEN-1:0]  dst_val,
    input  logic [XLEN-1:0]  src_val,
    input  logic [IMM_W-1:0] imm_val,
    input  logic [OFF_W-1:0] off_val,
    input  logic [PC_W-1:0]  pc_in,
    output logic             out_valid,
    output logic             taken,
    output logic [PC_W-1:0]  next_pc,
    output logic             call_local,
    output logic             call_helper,
    output logic             exit_req,
    output logic             illegal
);

    jdec_t           dec;
    logic [XLEN-1:0] imm_sx, opb;
    logic            cond_true, take_c;
    logic [PC_W-1:0] target_c;
    out_state_e      st_q, st_d;

    generate
        if (XLEN > IMM_W) begin : g_imm_op
            assign imm_sx = {{(XLEN-IMM_W){imm_val[IMM_W-1]}}, imm_val};
        end else begin : g_imm_op_tr
            assign imm_sx = imm_val[XLEN-1:0];
        end
    endgenerate

    assign opb = src_is_reg ? src_val : imm_sx;

    bcu_decode u_dec (
        .jcode     (jcode),
        .wide_cmp  (wide_cmp),
        .call_kind (call_kind),
        .dec       (dec)
    );

    bcu_cond_eval #(.XLEN(XLEN)) u_cond (
        .jcode     (jcode),
        .wide_cmp  (wide_cmp),
        .opa       (dst_val),
        .opb       (opb),
        .cond_true (cond_true)
    );

    assign take_c = dec.force_taken | (dec.use_cond & cond_true);

    bcu_target_gen #(.PC_W(PC_W), .IMM_W(IMM_W), .OFF_W(OFF_W)) u_tgt (
        .pc     (pc_in),
        .imm    (imm_val),
        .off    (off_val),
        .disp   (dec.disp),
        .taken  (take_c),
        .target (target_c)
    );

    always_comb begin
        unique case (st_q)
            OS_IDLE:   st_d = in_valid ? OS_RESULT : OS_IDLE;
            OS_RESULT: st_d = in_valid ? OS_RESULT : OS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= OS_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taken       <= 1'b0;
            next_pc     <= '0;
            call_local  <= 1'b0;
            call_helper <= 1'b0;
            exit_req    <= 1'b0;
            illegal     <= 1'b0;
        end else if (in_valid) begin
            taken       <= take_c;
            next_pc     <= target_c;
            call_local  <= dec.call_local;
            call_helper <= dec.call_helper;
            exit_req    <= dec.exit_req;
            illegal     <= dec.illegal;
        end
    end

    assign out_valid = (st_q == OS_RESULT);

endmodule

// File: rtl/bcu_branch_unit_chk.sv
module bcu_branch_unit_chk #(
    parameter int PC_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [3:0]      jcode,
    input logic            wide_cmp,
    input logic [PC_W-1:0] pc_in,
    input logic            out_valid,
    input logic            taken,
    input logic [PC_W-1:0] next_pc,
    input logic            call_local,
    input logic            call_helper,
    input logic            exit_req,
    input logic            illegal
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(next_pc) && $stable(taken))); // R2
    AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (taken || next_pc == $past(pc_in) + PC_W'(1))); // R8
    AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && jcode == 4'h0) |=> taken); // R9
    AST_LOCAL_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && call_local) |-> taken); // R10
    AST_HELPER_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && call_helper) |-> !taken); // R10
    AST_EXIT_WIDE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && jcode == 4'h9) |=> (exit_req == $past(wide_cmp) && !taken)); // R11
    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0({call_local, call_helper, exit_req, illegal})); // R12
    AST_ILLEGAL_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && illegal) |-> !taken); // R12

endmodule

bind bcu_branch_unit bcu_branch_unit_chk #(.PC_W(PC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .jcode       (jcode),
    .wide_cmp    (wide_cmp),
    .pc_in       (pc_in),
    .out_valid   (out_valid),
    .taken       (taken),
    .next_pc     (next_pc),
    .call_local  (call_local),
    .call_helper (call_helper),
    .exit_req    (exit_req),
    .illegal     (illegal)
);

// File: tb/tb_bcu_branch_unit.sv
`timescale 1ns/1ps
module tb_bcu_branch_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  jcode = '0;
    logic        wide_cmp = 1'b0;
    logic        src_is_reg = 1'b0;
    logic [1:0]  call_kind = '0;
    logic [63:0] dst_val = '0, src_val = '0, pc_in = '0;
    logic [31:0] imm_val = '0;
    logic [15:0] off_val = '0;
    logic        out_valid, taken, call_local, call_helper, exit_req, illegal;
    logic [63:0] next_pc;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bcu_branch_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .jcode(jcode),
        .wide_cmp(wide_cmp), .src_is_reg(src_is_reg), .call_kind(call_kind),
        .dst_val(dst_val), .src_val(src_val), .imm_val(imm_val),
        .off_val(off_val), .pc_in(pc_in), .out_valid(out_valid),
        .taken(taken), .next_pc(next_pc), .call_local(call_local),
        .call_helper(call_helper), .exit_req(exit_req), .illegal(illegal)
    );

    logic [63:0] pats [8];

    function automatic string tag_of(input logic [3:0] c, input logic k);
        case (c)
            4'h1, 4'h4, 4'h5:               return "R3";
            4'h2, 4'h3, 4'hA, 4'hB:         return "R4";
            4'h6, 4'h7, 4'hC, 4'hD:         return "R5";
            4'h0:                           return "R9";
            4'h8:                           return "R10";
            4'h9:                           return k ? "R11" : "R11 R12";
            default:                        return "R12";
        endcase
    endfunction

    // expected outputs packed as {valid, taken, cl, ch, ex, il, npc}
    function automatic logic [69:0] model(
        input logic [3:0] c, input logic w, input logic r, input logic [1:0] k,
        input logic [63:0] d, input logic [63:0] s, input logic [31:0] im,
        input logic [15:0] of, input logic [63:0] pc);
        logic [63:0] b, ua, ub;
        logic signed [63:0] sa, sb;
        logic t, cl, ch, ex, il;
        logic [63:0] disp;
        b  = r ? s : {{32{im[31]}}, im};
        ua = w ? d : {32'b0, d[31:0]};
        ub = w ? b : {32'b0, b[31:0]};
        sa = w ? d : {{32{d[31]}}, d[31:0]};
        sb = w ? b : {{32{b[31]}}, b[31:0]};
        t = 0; cl = 0; ch = 0; ex = 0; il = 0;
        disp = {{48{of[15]}}, of};
        case (c)
            4'h0: begin t = 1; if (!w) disp = {{32{im[31]}}, im}; end
            4'h1: t = (ua == ub);
            4'h5: t = (ua != ub);
            4'h4: t = ((ua & ub) != 0);
            4'h2: t = (ua > ub);
            4'h3: t = (ua >= ub);
            4'hA: t = (ua < ub);
            4'hB: t = (ua <= ub);
            4'h6: t = (sa > sb);
            4'h7: t = (sa >= sb);
            4'hC: t = (sa < sb);
            4'hD: t = (sa <= sb);
            4'h8: begin
                if (k == 2'd1) begin t = 1; cl = 1; end
                else if (k == 2'd3) il = 1;
                else ch = 1;
            end
            4'h9: if (w) ex = 1; else il = 1;
            default: il = 1;
        endcase
        return {1'b1, t, cl, ch, ex, il, pc + 64'd1 + (t ? disp : 64'd0)};
    endfunction

    function automatic logic [69:0] observed();
        return {out_valid, taken, call_local, call_helper, exit_req, illegal, next_pc};
    endfunction

    task automatic check(input string tag, input logic [69:0] act, input logic [69:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual v/t/cl/ch/ex/il=%b npc=%h expected %b npc=%h",
                     tag, act[69:64], act[63:0], exp[69:64], exp[63:0]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R2: watchdog expired, actual running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [69:0] exp_q;
        pats[0] = 64'h0000_0000_0000_0000;
        pats[1] = 64'h0000_0000_0000_0001;
        pats[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[3] = 64'h0000_0000_8000_0000;
        pats[4] = 64'h0000_0000_7FFF_FFFF;
        pats[5] = 64'h0000_0001_0000_0000;
        pats[6] = 64'h8000_0000_0000_0001;
        pats[7] = 64'h7FFF_FFFF_FFFF_FFFE;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: nothing accepted yet
        check("R1", observed(), 70'd0);

        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                for (int c = 0; c < 16; c++) begin
                    for (int w = 0; w < 2; w++) begin
                        for (int r = 0; r < 2; r++) begin
                            string tg;
                            in_valid   = 1'b1;
                            jcode      = 4'(c);
                            wide_cmp   = w[0];
                            src_is_reg = r[0];
                            call_kind  = 2'((i + j) % 4);
                            dst_val    = pats[i];
                            src_val    = pats[j];
                            imm_val    = pats[(j + 3) % 8][31:0];
                            if (r == 0) src_val = pats[(j + 5) % 8];
                            off_val    = 16'((i * 16'h1357) ^ (j * 16'h2468));
                            pc_in      = pats[(i + 2 * j) % 8];
                            exp_q = model(jcode, wide_cmp, src_is_reg, call_kind,
                                          dst_val, src_val, imm_val, off_val, pc_in);
                            tg = {tag_of(jcode, wide_cmp), (w == 0) ? " R6" : "",
                                  (r == 0) ? " R7" : "", " R8"};
                            @(negedge clk);
                            check(tg, observed(), exp_q);
                        end
                    end
                end
            end
            // R2: an idle cycle clears valid and keeps the result
            in_valid = 1'b0;
            jcode    = 4'h0;
            pc_in    = 64'h1234;
            @(negedge clk);
            check("R2", observed(), {1'b0, exp_q[68:0]});
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule